// File: doc/BRIEF.md
# Double-Buffered Output Compare Unit

This block is the compare stage of a 10-bit timer. The timer counter is outside the block. It arrives as `cnt_i`, together with a timer-tick enable and one-cycle strobes that mark the top and bottom of the count. There are four compare channels, numbered 0 to 3. Each channel compares the counter with its own active compare value. An equality raises a per-channel match flag on the following timer tick. That flag can request an interrupt, and it also drives a small waveform output stage. The output stage can toggle, clear or set the channel pin, or leave it unchanged.

Software reaches the block over an 8-bit register bus. A shared high-byte holding register supplies bits 9:8 of every compare value, so a low-byte write lands as one whole 10-bit value. The `pwm_mode_i` input selects how writes take effect:

- In normal mode, a compare write reaches the comparator at once.
- In PWM mode, the write sits in a shadow buffer. It is committed only on the boundary strobe chosen by the `UPDATE_AT_TOP` parameter, which keeps pulse widths whole.

Reads always return the newest written value.

Top module: `oc_unit`

## Requirements
- R1: A channel records a hit on a cycle with `tick_i`=1 and `cnt_i` equal to its active compare value. Its flag rises on the next `tick_i` cycle, not on the hit cycle. Equality on cycles with `tick_i`=0 is ignored.
- R2: `irq_o[k]` is high when flag k is set and enable bit k is set. The enable register is at address 6, with bit k for channel k. Flag k can be read at address 5, bit k.
- R3: A one-cycle pulse on `irq_ack_i[k]` clears flag k on that clock edge.
- R4: Writing address 5 clears each flag whose data bit is one. Flags whose data bit is zero are unchanged.
- R5: With `pwm_mode_i`=1, a compare write only fills the buffer. The active value is copied from the buffer on the `top_i` strobe when `UPDATE_AT_TOP`=1 (the default), or on `bot_i` otherwise. The other strobe has no effect.
- R6: With `pwm_mode_i`=0, a compare write becomes the active value on the same clock edge.
- R7: Reading a compare low byte returns bits 7:0 of the newest written value, including a value still pending in the buffer. The read also loads that value's bits 9:8 into the high-byte register. Reading address 4 returns the high-byte register zero-extended.
- R8: Writing address k (k = 0..3) stores the 10-bit value {high-byte register bits 1:0, data}. The high-byte register is written at address 4 from data bits 1:0.
- R9: The mode register is at address 7. Channel k's mode is in bits [2k+1:2k]. When a flag sets, the channel output toggles for mode 01, clears for 10, sets for 11, and is unchanged for 00.
- R10: A one-cycle `force_i[k]` applies channel k's mode action on that clock edge without setting the flag.
- R11: After reset, all flags, enables, modes, outputs, compare values and the high-byte register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick enable; marks timer clock cycles |
| cnt_i | input | 10 | Running counter value |
| top_i | input | 1 | One-cycle strobe at counter top |
| bot_i | input | 1 | One-cycle strobe at counter bottom |
| pwm_mode_i | input | 1 | 1 = PWM mode (buffered writes), 0 = normal |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_ack_i | input | 4 | Per-channel interrupt acknowledge |
| force_i | input | 4 | Per-channel force strobe |
| irq_o | output | 4 | Per-channel interrupt request |
| ocw_o | output | 4 | Per-channel waveform output |

## Verification
The assertions assume the following about the inputs:
- `wr_i` and `rd_i` are never both high in one cycle.
- A PWM-mode compare write never lands on the same cycle as the chosen boundary strobe.
- Acknowledges, flag-clearing writes and forces arrive only on cycles where the flag is not being set.

The stimulus keeps to this by driving every bus access, strobe and counter pulse as a separate event between falling edges. The counter normally rests at 0x200, which no programmed compare value uses, and only moves to a match value for a single cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_HOLD   = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_mode_e;

  function automatic logic oc_apply(oc_mode_e m, logic cur);
    case (m)
      OC_TOGGLE: return ~cur;
      OC_CLEAR:  return 1'b0;
      OC_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/oc_regfile.sv
module oc_regfile #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 10,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic                            rd_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [BUS_W-1:0]                wdata_i,
  output logic [BUS_W-1:0]                rdata_o,
  input  logic [N_CH-1:0][CNT_W-1:0]      buf_i,
  input  logic [N_CH-1:0]                 flag_i,
  output logic [N_CH-1:0]                 ch_wr_o,
  output logic [CNT_W-1:0]                wval_o,
  output logic [N_CH-1:0]                 w1c_o,
  output logic [N_CH-1:0]                 ie_o,
  output logic [2*N_CH-1:0]               mode_o
);
  localparam int HI_W = CNT_W - BUS_W;
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(N_CH + 1);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(N_CH + 2);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(N_CH + 3);

  logic [HI_W-1:0]   hi_q;
  logic [N_CH-1:0]   ie_q;
  logic [2*N_CH-1:0] mode_q;
  logic              sel_ch;
  logic [CH_W-1:0]   ch_idx;
  logic [CNT_W-1:0]  rd_val;

  assign sel_ch = addr_i < ADDR_W'(N_CH);
  assign ch_idx = addr_i[CH_W-1:0];
  assign rd_val = buf_i[ch_idx];
  assign wval_o = {hi_q, wdata_i};
  assign ie_o   = ie_q;
  assign mode_o = mode_q;

  always_comb begin
    for (int k = 0; k < N_CH; k++) ch_wr_o[k] = wr_i && (addr_i == ADDR_W'(k));
    w1c_o = (wr_i && addr_i == A_FLAG) ? wdata_i[N_CH-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      ie_q   <= '0;
      mode_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_HI:    hi_q   <= wdata_i[HI_W-1:0];
        A_IE:    ie_q   <= wdata_i[N_CH-1:0];
        A_MODE:  mode_q <= wdata_i[2*N_CH-1:0];
        default: ;
      endcase
    end else if (rd_i && sel_ch) begin
      // low-byte read stages the upper bits for the next read
      hi_q <= rd_val[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ch)                 rdata_o = rd_val[BUS_W-1:0];
    else if (addr_i == A_HI)    rdata_o = BUS_W'(hi_q);
    else if (addr_i == A_FLAG)  rdata_o = BUS_W'(flag_i);
    else if (addr_i == A_IE)    rdata_o = BUS_W'(ie_q);
    else if (addr_i == A_MODE)  rdata_o = BUS_W'(mode_q);
  end

  p_hi_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_ch) |=> hi_q == $past(rd_val[CNT_W-1:BUS_W]));

  p_hi_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_HI) |=> hi_q == $past(wdata_i[HI_W-1:0]));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pwm_i,
  input  logic             upd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wval_i,
  input  oc_mode_e         mode_i,
  input  logic             force_i,
  input  logic             ack_i,
  input  logic             w1c_i,
  output logic [CNT_W-1:0] buf_o,
  output logic             flag_o,
  output logic             ocw_o
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             hit_q, flag_q, ocw_q;
  logic             eq, set_flag;

  assign eq       = (cnt_i == act_q);
  assign set_flag = tick_i && hit_q;
  assign buf_o    = buf_q;
  assign flag_o   = flag_q;
  assign ocw_o    = ocw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
      ocw_q  <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wval_i;
      if (wr_i && !pwm_i)      act_q <= wval_i;
      else if (pwm_i && upd_i) act_q <= buf_q;
      // match is held until the next timer tick
      if (tick_i) hit_q <= eq;
      if (set_flag)            flag_q <= 1'b1;
      else if (ack_i || w1c_i) flag_q <= 1'b0;
      if (set_flag || force_i) ocw_q <= oc_apply(mode_i, ocw_q);
    end
  end

  p_flag_after_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i && hit_q));

  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_flag) |=> !flag_q);

  p_w1c_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_i && !set_flag) |=> !flag_q);

  p_pwm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !upd_i) |=> $stable(act_q));

  p_pwm_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && upd_i && !wr_i) |=> act_q == $past(buf_q));

  p_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pwm_i) |=> act_q == $past(wval_i));

  p_set_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flag && mode_i == OC_SET) |=> ocw_q);

  p_force_no_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !set_flag && !flag_q) |=> !flag_q);
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int N_CH          = 4,
  parameter int CNT_W         = 10,
  parameter int BUS_W         = 8,
  parameter int ADDR_W        = 4,
  parameter bit UPDATE_AT_TOP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              top_i,
  input  logic              bot_i,
  input  logic              pwm_mode_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   irq_ack_i,
  input  logic [N_CH-1:0]   force_i,
  output logic [N_CH-1:0]   irq_o,
  output logic [N_CH-1:0]   ocw_o
);
  logic [N_CH-1:0][CNT_W-1:0] buf_v;
  logic [N_CH-1:0]            flag_v, ch_wr, w1c, ie;
  logic [2*N_CH-1:0]          mode;
  logic [CNT_W-1:0]           wval;
  logic                       upd;

  generate
    if (UPDATE_AT_TOP) begin : g_upd_top
      assign upd = top_i;
    end else begin : g_upd_bot
      assign upd = bot_i;
    end
  endgenerate

  oc_regfile #(
    .N_CH(N_CH), .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .buf_i   (buf_v),
    .flag_i  (flag_v),
    .ch_wr_o (ch_wr),
    .wval_o  (wval),
    .w1c_o   (w1c),
    .ie_o    (ie),
    .mode_o  (mode)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .cnt_i   (cnt_i),
      .pwm_i   (pwm_mode_i),
      .upd_i   (upd),
      .wr_i    (ch_wr[k]),
      .wval_i  (wval),
      .mode_i  (oc_mode_e'(mode[2*k +: 2])),
      .force_i (force_i[k]),
      .ack_i   (irq_ack_i[k]),
      .w1c_i   (w1c[k]),
      .buf_o   (buf_v[k]),
      .flag_o  (flag_v[k]),
      .ocw_o   (ocw_o[k])
    );
  end

  assign irq_o = flag_v & ie;

  p_irq_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(N_CH + 2) && wdata_i[N_CH-1:0] == '0) |=> irq_o == '0);
endmodule

// File: tb/tb_oc_unit.sv
`timescale 1ns/1ps
module tb_oc_unit;
  localparam int IDLE = 10'h200;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic [9:0] cnt_i = 10'(IDLE);
  logic       top_i = 1'b0, bot_i = 1'b0, pwm_mode_i = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] irq_ack_i = '0, force_i = '0, irq_o, ocw_o;

  oc_unit dut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {int kind; int idx; int exp; string req;} item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  // driver side: queue an expectation, sampled by the monitor at once
  task automatic expect_v(int kind, int idx, int exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb.push_back(it);
    #0.1;
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      int act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      case (it.kind)
        0:       act = int'(irq_o[it.idx]);
        1:       act = int'(ocw_o[it.idx]);
        default: act = int'(rdata_o);
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic bus_wr(int a, int d);
    wr_i = 1'b1; addr_i = 4'(a); wdata_i = 8'(d);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(int a, int exp, string req);
    rd_i = 1'b1; addr_i = 4'(a);
    #0.5;
    expect_v(2, 0, exp, req);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // one-cycle counter excursion; flag visible at the returning negedge
  task automatic pulse_cnt(int v);
    cnt_i = 10'(v);
    @(negedge clk_i);
    cnt_i = 10'(IDLE);
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    for (int k = 0; k < 4; k++) begin
      expect_v(0, k, 0, "R11");
      expect_v(1, k, 0, "R11");
    end
    bus_rd(5, 0, "R11"); bus_rd(6, 0, "R11"); bus_rd(7, 0, "R11");
    bus_rd(4, 0, "R11"); bus_rd(0, 0, "R11");

    bus_wr(6, 8'h0F);
    // R8 / R6: channel 0 = 0x155 in normal mode
    bus_wr(4, 1); bus_wr(0, 8'h55);

    // R1: equality without tick is ignored
    tick_i = 1'b0; cnt_i = 10'h155;
    repeat (2) @(negedge clk_i);
    cnt_i = 10'(IDLE); tick_i = 1'b1;
    repeat (2) @(negedge clk_i);
    expect_v(0, 0, 0, "R1");
    // R1: flag rises one tick after the hit
    cnt_i = 10'h155;
    @(negedge clk_i);
    cnt_i = 10'(IDLE);
    expect_v(0, 0, 0, "R1");
    @(negedge clk_i);
    expect_v(0, 0, 1, "R1");

    // R4: write-one clears, zero does not
    bus_wr(5, 8'h00); expect_v(0, 0, 1, "R4");
    bus_wr(5, 8'h01); expect_v(0, 0, 0, "R4");

    // R2: disabled interrupt, flag still readable
    bus_wr(6, 8'h0E);
    pulse_cnt(10'h155);
    expect_v(0, 0, 0, "R2");
    bus_rd(5, 8'h01, "R2");
    bus_wr(5, 8'h01); bus_wr(6, 8'h0F);

    // R3: acknowledge clears
    pulse_cnt(10'h155);
    expect_v(0, 0, 1, "R3");
    irq_ack_i = 4'b0001;
    @(negedge clk_i);
    irq_ack_i = '0;
    expect_v(0, 0, 0, "R3");

    // R7 / R8: high byte staging
    bus_wr(4, 2); bus_wr(0, 8'h34); bus_wr(4, 0);
    bus_rd(4, 0, "R7");
    bus_rd(0, 8'h34, "R7");
    bus_rd(4, 8'h02, "R7");
    bus_wr(4, 0);
    pulse_cnt(10'h034); expect_v(0, 0, 0, "R8");
    pulse_cnt(10'h234); expect_v(0, 0, 1, "R8");
    bus_wr(5, 8'h0F);

    // R5: channel 1 buffered in PWM mode, commit on top only
    bus_wr(1, 8'h80);
    pwm_mode_i = 1'b1;
    bus_wr(1, 8'h40);
    bus_rd(1, 8'h40, "R5");
    pulse_cnt(10'h040); expect_v(0, 1, 0, "R5");
    bot_i = 1'b1; @(negedge clk_i); bot_i = 1'b0;
    pulse_cnt(10'h040); expect_v(0, 1, 0, "R5");
    pulse_cnt(10'h080); expect_v(0, 1, 1, "R5");
    bus_wr(5, 8'h02);
    top_i = 1'b1; @(negedge clk_i); top_i = 1'b0;
    pulse_cnt(10'h040); expect_v(0, 1, 1, "R5");
    bus_wr(5, 8'h0F);
    pwm_mode_i = 1'b0;
    // R6: normal mode write is live at once
    bus_wr(1, 8'h44);
    pulse_cnt(10'h044); expect_v(0, 1, 1, "R6");
    bus_wr(5, 8'h0F);

    // R9: channel 2 waveform modes, compare 0x123
    bus_wr(4, 1); bus_wr(2, 8'h23); bus_wr(4, 0);
    bus_wr(7, 8'h10);
    pulse_cnt(10'h123); expect_v(1, 2, 1, "R9");
    pulse_cnt(10'h123); expect_v(1, 2, 0, "R9");
    bus_wr(7, 8'h30);
    pulse_cnt(10'h123); expect_v(1, 2, 1, "R9");
    pulse_cnt(10'h123); expect_v(1, 2, 1, "R9");
    bus_wr(7, 8'h00);
    pulse_cnt(10'h123); expect_v(1, 2, 1, "R9");
    bus_wr(7, 8'h20);
    pulse_cnt(10'h123); expect_v(1, 2, 0, "R9");
    expect_v(1, 0, 0, "R9");
    bus_wr(5, 8'h0F);

    // R10: force on channel 3
    bus_wr(7, 8'hC0);
    force_i = 4'b1000; @(negedge clk_i); force_i = '0;
    expect_v(1, 3, 1, "R10");
    expect_v(0, 3, 0, "R10");
    bus_wr(7, 8'h40);
    force_i = 4'b1000; @(negedge clk_i); force_i = '0;
    expect_v(1, 3, 0, "R10");
    bus_rd(5, 0, "R10");

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule